// File: doc/BRIEF.md
# Windowed Watchdog with Two-Stage Fail Escalation

This block supervises a host processor that must pulse a trigger input at the right times. Once the watchdog is enabled it opens a long initial window. A trigger inside that window starts the steady-state rhythm. In that rhythm a closed window, in which triggering is forbidden, is followed by an open window, in which one trigger is expected. Badly timed or missing triggers raise a saturating failure counter. Well-timed triggers lower it.

The counter drives two escalation stages. When it passes the fail threshold, the block drops its enable-drive output to put the system in a safe state. It also sets a sticky error flag and pulls an active-low interrupt. When it passes the fail threshold plus a separate reset threshold, and reset is enabled, the block drives an active-low reset output low for a fixed number of cycles. It then reopens the long window and keeps the count. A host that never recovers sees a bounded series of reset pulses, after which the reset output stays low until the watchdog is disabled. Window lengths are counted in ticks of an internal prescaler.

Top module: `wdog_escalate`

## Requirements
- R1: After the synchronous reset `rst`, `drv_en`=1, `err_flag`=0, `irq_n`=1 and `rst_n`=1.
- R2: While `wd_en`=0, trigger pulses and elapsed time cause no failure, and every output keeps its value.
- R3: After `wd_en` rises, a long window of (`long_len`+1) ticks runs. A trigger edge inside it starts the closed window without a failure. Expiry with no trigger counts one failure and restarts the long window.
- R4: A trigger edge inside the closed window (length `win1_len`+1 ticks) counts one failure and restarts the closed window.
- R5: If the open window (length `win2_len`+1 ticks) ends with no trigger edge, one failure is counted and the closed window restarts.
- R6: A trigger edge inside the open window lowers the failure count by one, saturating at zero, and restarts the closed window.
- R7: A failure that leaves the count above `fail_thr` sets `err_flag`, drives `irq_n` low and clears `drv_en`. `drv_en` stays low until `wd_en` is dropped.
- R8: While failures leave the count at or below `fail_thr`, `err_flag`, `irq_n` and `drv_en` stay unchanged.
- R9: A failure that leaves the count above `fail_thr`+`rst_thr` while `rst_en`=1 drives `rst_n` low for exactly RST_CYC cycles. The block then reopens the long window with the count preserved.
- R10: With `rst_en`=0, `rst_n` stays high whatever the count. The first stage still acts.
- R11: `err_flag` is sticky until an `err_clr` pulse. `irq_n` is the inverse of the flag and is released only when the flag clears. If a new error and a clear arrive in the same cycle, the error wins.
- R12: After MAX_PULSES (7 by default) reset pulses, the next reset request holds `rst_n` low until `wd_en` is dropped.
- R13: Dropping `wd_en` clears the failure count, the pulse count and the latched reset. It restores `drv_en`=1 and `rst_n`=1 and leaves `err_flag` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en | input | 1 | Watchdog enable |
| trig | input | 1 | Asynchronous service pulse from the host; its rising edge counts |
| rst_en | input | 1 | Permits the reset stage |
| fail_thr | input | CNT_W | First-stage threshold |
| rst_thr | input | CNT_W | Extra count above `fail_thr` that triggers a reset |
| long_len | input | WIN_W | Long window length minus one, in ticks |
| win1_len | input | WIN_W | Closed window length minus one, in ticks |
| win2_len | input | WIN_W | Open window length minus one, in ticks |
| err_clr | input | 1 | Clears the sticky error flag |
| drv_en | output | 1 | Enable-drive, low in safe state |
| err_flag | output | 1 | Sticky error flag |
| irq_n | output | 1 | Active-low interrupt |
| rst_n | output | 1 | Active-low reset output |

## Verification
The bench aims triggers at the middle of each window. It then checks that an early trigger counts as a failure while an on-time one pays a failure back, and that a good trigger at a zero count does not wrap the counter. A wrapping counter would raise the error flag on the next single failure. It measures the reset pulse width and shows that the count survives a reset: a design that cleared it would not reset again after one more failure. It also counts pulses up to the latch-low point, which an off-by-one pulse counter would reach one pulse early or late. Finally it shows that disabling frees the latched reset and rearms the pulse counter.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_LONG   = 3'd1,
    WS_CLOSED = 3'd2,
    WS_OPEN   = 3'd3,
    WS_RSTP   = 3'd4,
    WS_LOCK   = 3'd5
  } wd_state_t;
endpackage

// File: rtl/wdog_tick.sv
`timescale 1ns/1ps
// Timebase prescaler: one tick every TICK_DIV cycles, restartable.
module wdog_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || restart)   pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_trig_edge.sv
`timescale 1ns/1ps
// Synchronises the host trigger and produces a one-cycle rising-edge pulse.
module wdog_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= trig;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], trig};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      edge_o <= sync_q[SYNC_STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/wdog_seq.sv
`timescale 1ns/1ps
// Window sequencer: long / closed / open windows, reset pulse and lock.
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int WIN_W      = 8,
  parameter int RST_CYC    = 16,
  parameter int MAX_PULSES = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_en,
  input  logic             trig_edge,
  input  logic             tick,
  input  logic [WIN_W-1:0] long_len,
  input  logic [WIN_W-1:0] w1_len,
  input  logic [WIN_W-1:0] w2_len,
  input  logic             rst_req,
  output logic             fail_ev,
  output logic             good_ev,
  output logic             win_restart,
  output logic             rst_n_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);
  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYC - 1);
  localparam logic [PC_W-1:0] PC_MAX  = PC_W'(MAX_PULSES);

  wd_state_t        state, nxt;
  logic [WIN_W-1:0] tick_cnt, cur_len;
  logic [RC_W-1:0]  rc;
  logic [PC_W-1:0]  pulses;
  logic             expire;

  // Event decode
  always_comb begin
    case (state)
      WS_LONG:   cur_len = long_len;
      WS_CLOSED: cur_len = w1_len;
      WS_OPEN:   cur_len = w2_len;
      default:   cur_len = '1;
    endcase
    expire  = tick && (tick_cnt == cur_len);
    fail_ev = wd_en && ((state == WS_LONG   && !trig_edge && expire) ||
                        (state == WS_CLOSED &&  trig_edge)           ||
                        (state == WS_OPEN   && !trig_edge && expire));
    good_ev = wd_en && (state == WS_OPEN) && trig_edge;
  end

  // Next-state decode
  always_comb begin
    nxt         = state;
    win_restart = 1'b0;
    if (!wd_en) begin
      nxt         = WS_IDLE;
      win_restart = 1'b1;
    end else if (fail_ev && rst_req) begin
      nxt = (pulses == PC_MAX) ? WS_LOCK : WS_RSTP;
    end else begin
      case (state)
        WS_IDLE: begin
          nxt         = WS_LONG;
          win_restart = 1'b1;
        end
        WS_LONG: begin
          if (trig_edge) begin
            nxt         = WS_CLOSED;
            win_restart = 1'b1;
          end else if (expire) begin
            win_restart = 1'b1;
          end
        end
        WS_CLOSED: begin
          if (trig_edge) begin
            win_restart = 1'b1;
          end else if (expire) begin
            nxt         = WS_OPEN;
            win_restart = 1'b1;
          end
        end
        WS_OPEN: begin
          if (trig_edge || expire) begin
            nxt         = WS_CLOSED;
            win_restart = 1'b1;
          end
        end
        WS_RSTP: begin
          if (rc == RC_LAST) begin
            nxt         = WS_LONG;
            win_restart = 1'b1;
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WS_IDLE;
      tick_cnt <= '0;
      rc       <= '0;
      pulses   <= '0;
      rst_n_o  <= 1'b1;
    end else begin
      state <= nxt;
      if (win_restart) tick_cnt <= '0;
      else if (tick)   tick_cnt <= tick_cnt + 1'b1;
      if (state == WS_RSTP && nxt == WS_RSTP) rc <= rc + 1'b1;
      else                                    rc <= '0;
      if (!wd_en) pulses <= '0;
      else if (nxt == WS_RSTP && state != WS_RSTP && pulses != PC_MAX)
        pulses <= pulses + 1'b1;
      rst_n_o <= !(nxt == WS_RSTP || nxt == WS_LOCK);
    end
  end

  // R12: the latched reset holds while the watchdog stays enabled
  assert_lock_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (state == WS_LOCK && wd_en) |=> (state == WS_LOCK));

  // R9: a reset pulse ends only after its full length (or on disable)
  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ($past(rc) == RC_LAST || !$past(wd_en)));

  // R2: after a disabled cycle the reset output is released
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!wd_en) |-> rst_n_o);
endmodule

// File: rtl/wdog_esc.sv
`timescale 1ns/1ps
// Failure counter and two-stage escalation.
module wdog_esc #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_en,
  input  logic             fail_ev,
  input  logic             good_ev,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] fail_thr,
  input  logic [CNT_W-1:0] rst_thr,
  input  logic             err_clr,
  output logic             rst_req,
  output logic             drv_en,
  output logic             err_flag,
  output logic             irq_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, cnt_up;
  logic [CNT_W:0]   combo_thr;
  logic             stage1, err_nx;

  always_comb begin
    cnt_up    = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    combo_thr = {1'b0, fail_thr} + {1'b0, rst_thr};
    stage1    = fail_ev && (cnt_up > fail_thr);
    rst_req   = fail_ev && rst_en && ({1'b0, cnt_up} > combo_thr);
    if (stage1 || rst_req) err_nx = 1'b1;
    else if (err_clr)      err_nx = 1'b0;
    else                   err_nx = err_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      drv_en   <= 1'b1;
      err_flag <= 1'b0;
      irq_n    <= 1'b1;
    end else begin
      if (!wd_en)                     cnt <= '0;
      else if (fail_ev)               cnt <= cnt_up;
      else if (good_ev && cnt != '0)  cnt <= cnt - 1'b1;
      if (!wd_en)      drv_en <= 1'b1;
      else if (stage1) drv_en <= 1'b0;
      err_flag <= err_nx;
      irq_n    <= ~err_nx;
    end
  end

  // R6: a good trigger at zero count leaves the counter at zero
  assert_cnt_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (good_ev && cnt == '0) |=> (cnt == '0));

  // R7: safe state holds while enabled
  assert_drv_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!drv_en && wd_en) |=> !drv_en);

  // R11: the flag falls only after a clear request
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(err_flag) |-> $past(err_clr));
endmodule

// File: rtl/wdog_escalate.sv
`timescale 1ns/1ps
// Top: windowed watchdog with two-stage escalation.
module wdog_escalate #(
  parameter int TICK_DIV    = 1000,
  parameter int WIN_W       = 8,
  parameter int CNT_W       = 4,
  parameter int RST_CYC     = 16,
  parameter int MAX_PULSES  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_en,
  input  logic             trig,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] fail_thr,
  input  logic [CNT_W-1:0] rst_thr,
  input  logic [WIN_W-1:0] long_len,
  input  logic [WIN_W-1:0] win1_len,
  input  logic [WIN_W-1:0] win2_len,
  input  logic             err_clr,
  output logic             drv_en,
  output logic             err_flag,
  output logic             irq_n,
  output logic             rst_n
);
  logic trig_edge, tick, win_restart, fail_ev, good_ev, rst_req;

  wdog_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .trig(trig), .edge_o(trig_edge));

  wdog_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(win_restart), .tick(tick));

  wdog_seq #(.WIN_W(WIN_W), .RST_CYC(RST_CYC), .MAX_PULSES(MAX_PULSES)) u_seq (
    .clk(clk), .rst(rst), .wd_en(wd_en), .trig_edge(trig_edge), .tick(tick),
    .long_len(long_len), .w1_len(win1_len), .w2_len(win2_len),
    .rst_req(rst_req), .fail_ev(fail_ev), .good_ev(good_ev),
    .win_restart(win_restart), .rst_n_o(rst_n));

  wdog_esc #(.CNT_W(CNT_W)) u_esc (
    .clk(clk), .rst(rst), .wd_en(wd_en), .fail_ev(fail_ev), .good_ev(good_ev),
    .rst_en(rst_en), .fail_thr(fail_thr), .rst_thr(rst_thr), .err_clr(err_clr),
    .rst_req(rst_req), .drv_en(drv_en), .err_flag(err_flag), .irq_n(irq_n));

  // R10: a reset pulse starts only when reset was permitted
  assert_rst_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n) |-> $past(rst_en));

  // R11: interrupt mirrors the flag
  assert_irq_mirror_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_n == !err_flag));
endmodule

// File: tb/wdog_escalate_tb.sv
`timescale 1ns/1ps
module wdog_escalate_tb_top;
  localparam int WIN_W = 8;
  localparam int CNT_W = 4;
  localparam int RSTC  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_en = 1'b0, trig = 1'b0, rst_en = 1'b0, err_clr = 1'b0;
  logic [CNT_W-1:0] fail_thr = '0, rst_thr = '0;
  logic [WIN_W-1:0] long_len = 8'd9, win1_len = 8'd3, win2_len = 8'd3;
  logic drv_en, err_flag, irq_n, rst_n;

  always #4 clk = ~clk;

  wdog_escalate #(.TICK_DIV(4), .WIN_W(WIN_W), .CNT_W(CNT_W), .RST_CYC(RSTC),
                  .MAX_PULSES(7), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .wd_en(wd_en), .trig(trig), .rst_en(rst_en),
    .fail_thr(fail_thr), .rst_thr(rst_thr), .long_len(long_len),
    .win1_len(win1_len), .win2_len(win2_len), .err_clr(err_clr),
    .drv_en(drv_en), .err_flag(err_flag), .irq_n(irq_n), .rst_n(rst_n));

  typedef struct {
    string tag;
    logic  drv, err, irq, rstn;
  } exp_t;
  exp_t sb_q[$];

  int n_run = 0, n_fail = 0;
  int falls = 0, rises = 0, low_run = 0, last_width = 0;
  logic prev_rstn = 1'b1;
  bit done = 0;

  // Monitor: pops expectations and compares, tracks reset pulses
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if ({drv_en, err_flag, irq_n, rst_n} !== {e.drv, e.err, e.irq, e.rstn}) begin
        n_fail++;
        $display("FAIL %s act drv/err/irq/rstn=%b%b%b%b exp=%b%b%b%b", e.tag,
                 drv_en, err_flag, irq_n, rst_n, e.drv, e.err, e.irq, e.rstn);
      end
    end
    if (!rst) begin
      if (prev_rstn && !rst_n) begin falls++; low_run = 0; end
      if (!rst_n) low_run++;
      if (!prev_rstn && rst_n) begin rises++; last_width = low_run; end
      prev_rstn = rst_n;
    end
  end

  task automatic expect_outs(string tag, logic d, logic e, logic i, logic r);
    exp_t x;
    x.tag = tag; x.drv = d; x.err = e; x.irq = i; x.rstn = r;
    sb_q.push_back(x);
  endtask

  task automatic chk_val(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  // Trigger pulse: high 2 cycles, then 4 quiet cycles (returns rise+6)
  task automatic pulse();
    trig <= 1'b1; cyc(2); trig <= 1'b0; cyc(4);
  endtask
  task automatic good_trig();  cyc(18); pulse(); endtask  // lands mid open window
  task automatic early_trig(); cyc(2);  pulse(); endtask  // lands in closed window
  task automatic miss();       cyc(32);          endtask  // one open-window expiry

  task automatic start_seq();  // enable and service the long window
    wd_en <= 1'b1; cyc(10); pulse();
  endtask

  task automatic disable_clear();
    wd_en <= 1'b0; cyc(3);
    err_clr <= 1'b1; cyc(1); err_clr <= 1'b0; cyc(2);
  endtask

  initial begin
    cyc(5); rst <= 1'b0; cyc(2);
    expect_outs("R1 reset state", 1, 0, 1, 1); cyc(2);

    // R2: disabled, triggers ignored
    fail_thr <= '0; rst_en <= 1'b1;
    pulse(); pulse(); pulse(); cyc(60);
    expect_outs("R2 disabled ignores triggers", 1, 0, 1, 1); cyc(2);
    chk_val("R2 no reset pulse while disabled", falls, 0);

    // R3: long window expiry counts a failure
    rst_en <= 1'b0;
    wd_en <= 1'b1; cyc(30);
    expect_outs("R3 before long expiry", 1, 0, 1, 1); cyc(20);
    expect_outs("R3/R7 long expiry fails", 0, 1, 0, 1); cyc(1);
    wd_en <= 1'b0; cyc(3);
    expect_outs("R13 disable keeps flag, restores drv", 1, 1, 0, 1); cyc(1);
    err_clr <= 1'b1; cyc(1); err_clr <= 1'b0; cyc(2);
    expect_outs("R11 clear releases irq", 1, 0, 1, 1); cyc(1);

    // R3/R6: trigger in long window, then good triggers
    start_seq(); good_trig(); good_trig(); good_trig();
    expect_outs("R3 long trigger and open triggers no failure", 1, 0, 1, 1);
    // R4: early trigger
    early_trig();
    expect_outs("R4 closed-window trigger fails", 0, 1, 0, 1);
    disable_clear();

    // R5: missed open window
    start_seq(); good_trig(); miss();
    expect_outs("R5 open window miss fails", 0, 1, 0, 1);
    disable_clear();

    // R6/R8: threshold 1, decrement with saturation
    fail_thr <= 4'd1;
    start_seq(); early_trig();
    expect_outs("R8 count at threshold no flag", 1, 0, 1, 1);
    good_trig(); good_trig(); early_trig();
    expect_outs("R6 decrement saturates at zero", 1, 0, 1, 1);
    early_trig();
    expect_outs("R7 count above threshold", 0, 1, 0, 1);
    wd_en <= 1'b0; cyc(50);
    expect_outs("R11 flag sticky while idle", 1, 1, 0, 1); cyc(1);
    err_clr <= 1'b1; trig <= 1'b0; cyc(1); err_clr <= 1'b0; cyc(2);
    expect_outs("R11 cleared", 1, 0, 1, 1); cyc(1);

    // R9: reset pulse, count preserved
    fail_thr <= '0; rst_thr <= 4'd1; rst_en <= 1'b1;
    falls = 0; rises = 0;
    wd_en <= 1'b1; cyc(50);
    expect_outs("R9 first stage only", 0, 1, 0, 1); cyc(1);
    while (rises == 0 && falls < 5) cyc(1);
    chk_val("R9 reset pulse width", last_width, RSTC);
    cyc(10); pulse(); early_trig(); cyc(2);
    chk_val("R9 count kept across reset", falls, 2);
    cyc(20);
    disable_clear();

    // R10: reset disabled
    rst_thr <= '0; rst_en <= 1'b0; falls = 0;
    wd_en <= 1'b1; cyc(150);
    expect_outs("R10 no reset when disabled", 0, 1, 0, 1); cyc(1);
    chk_val("R10 no reset edges", falls, 0);
    disable_clear();

    // R12: pulses then latch low
    rst_en <= 1'b1; falls = 0; rises = 0;
    wd_en <= 1'b1; cyc(700);
    chk_val("R12 pulse count before latch", rises, 7);
    expect_outs("R12 reset latched low", 0, 1, 0, 0); cyc(100);
    expect_outs("R12 still latched", 0, 1, 0, 0); cyc(1);

    // R13: disable clears latch and pulse count
    wd_en <= 1'b0; cyc(3);
    expect_outs("R13 disable releases reset", 1, 1, 0, 1); cyc(1);
    err_clr <= 1'b1; cyc(1); err_clr <= 1'b0;
    wd_en <= 1'b1; cyc(30);
    expect_outs("R13 re-enabled before expiry", 1, 0, 1, 1); cyc(30);
    expect_outs("R13 pulse count rearmed", 0, 1, 0, 1); cyc(2);
    wd_en <= 1'b0; cyc(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1..: act=timeout exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule